// File: doc/BRIEF.md
# Locality-Aware Request Injection Throttle

This block is a per-core admission gate placed between a core's load/store unit and the on-chip network. Each warp hands over its memory requests as one group. Every request names a target memory controller, a bank and a tag. The gate either admits the whole group or holds it back, and it never admits part of a group. To decide, it keeps one in-flight counter per (controller, bank) pair and a single count of requests outstanding from this core. A group is admitted only when every bank it touches has nothing in flight from this core and the outstanding count is below a limit that software can change at run time.

An admitted group is sent to the network one request per cycle, in slot order, with a valid/ready handshake on the output. A completion notice from memory names a (controller, bank) pair. It lowers that pair's counter and the outstanding count. The core reads the outstanding count directly.

Top module: `lcg_inject_gate`

## Requirements
- R1: After reset, `inj_valid` is 0, `out_count` is 0 and every pair counter is zero.
- R2: When no group is being sent, `grp_ready` is 1 if and only if every request in slots 0 to `grp_len`-1 targets a pair whose counter is zero and `out_count` is below `cfg_limit`. The group is accepted on a clock edge where `grp_valid` and `grp_ready` are both 1.
- R3: A group with any target pair whose counter is nonzero is throttled. `grp_ready` stays 0 and nothing from the group is injected.
- R4: A group is throttled while `out_count` is greater than or equal to `cfg_limit`. A new `cfg_limit` value takes effect in the next cycle.
- R5: An accepted group is sent one request per handshake, in slot order 0 to `grp_len`-1. While `inj_ready` is 0, `inj_valid` and the presented request stay unchanged.
- R6: While a group is being sent, `grp_ready` is 0 even when the offered group would otherwise pass.
- R7: Each output handshake adds one to the counter of the target pair and one to `out_count`. Counters saturate at their maximum.
- R8: A completion lowers its pair's counter and `out_count` by one. When an injection and a counted completion happen in the same cycle, `out_count` does not change.
- R9: A completion that names a pair whose counter is zero is ignored. No counter goes below zero, and `out_count` is unchanged.
- R10: Each injected request carries the controller, bank and tag from its slot unchanged. Slot i uses bits [i*W +: W] of the matching flat input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_limit | input | OUT_W | Run-time limit on outstanding requests |
| grp_valid | input | 1 | A warp group is offered |
| grp_ready | output | 1 | Gate accepts the offered group |
| grp_len | input | $clog2(GRP_MAX+1) | Number of requests in the group, 1 to GRP_MAX |
| grp_mc | input | GRP_MAX*MC_W | Controller id per slot, flat |
| grp_bank | input | GRP_MAX*BANK_W | Bank id per slot, flat |
| grp_tag | input | GRP_MAX*TAG_W | Request tag per slot, flat |
| inj_valid | output | 1 | Injected request valid |
| inj_ready | input | 1 | Network accepts the request |
| inj_mc | output | MC_W | Controller of the injected request |
| inj_bank | output | BANK_W | Bank of the injected request |
| inj_tag | output | TAG_W | Tag of the injected request |
| cpl_valid | input | 1 | Completion notice |
| cpl_mc | input | MC_W | Controller of the completion |
| cpl_bank | input | BANK_W | Bank of the completion |
| out_count | output | OUT_W | Requests outstanding from this core |

## Verification
The admission decision is driven with several kinds of groups. Groups on fresh banks must pass. Groups that reuse a bank with a request in flight, or that add a second target to such a bank, must be held, which separates a per-pair check from a per-group one. The limit is moved below and then above the live count, which shows that the run-time limit acts on its own and not through the bank check. A group whose bank is still queued but not yet sent is offered during a stalled injection, so that holding because the gate is busy can be told apart from holding because of the bank check. The same group is offered again after the drain, where the bank check now holds it. Completions are issued on the same edge as an injection and to idle pairs, so a net-zero update can be told apart from a lost one and from an underflow.

// File: rtl/lcg_pkg.sv
package lcg_pkg;
    localparam int LCG_MCS   = 2;
    localparam int LCG_BANKS = 4;
    localparam int TAG_W     = 8;
    localparam int MC_W      = (LCG_MCS > 1) ? $clog2(LCG_MCS) : 1;
    localparam int BANK_W    = (LCG_BANKS > 1) ? $clog2(LCG_BANKS) : 1;
    localparam int PAIRS     = LCG_MCS * LCG_BANKS;

    typedef logic [MC_W-1:0]   mc_id_t;
    typedef logic [BANK_W-1:0] bank_id_t;
    typedef logic [TAG_W-1:0]  tag_t;

    typedef struct packed {
        mc_id_t   mc;
        bank_id_t bank;
        tag_t     tag;
    } lcg_req_t;

    typedef enum logic {
        LCG_IDLE,
        LCG_SEND
    } lcg_state_e;

    function automatic int pair_of(mc_id_t mc, bank_id_t bank);
        return int'(mc) * LCG_BANKS + int'(bank);
    endfunction
endpackage

// File: rtl/lcg_sat_cnt.sv
module lcg_sat_cnt #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         inc,
    input  logic         dec,
    output logic [W-1:0] cnt
);
    localparam logic [W-1:0] CMAX = {W{1'b1}};

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (inc && !dec) begin
            if (cnt != CMAX) cnt <= cnt + 1'b1;
        end else if (dec && !inc) begin
            if (cnt != '0) cnt <= cnt - 1'b1;
        end
    end

    // R9: a lone decrement at zero must not wrap
    p_no_wrap_r9: assert property (@(posedge clk) disable iff (rst)
        (cnt == '0 && dec && !inc) |=> cnt == '0);
    // R7: a lone increment at the top must not wrap
    p_no_overflow_r7: assert property (@(posedge clk) disable iff (rst)
        (cnt == CMAX && inc && !dec) |=> cnt == CMAX);
endmodule

// File: rtl/lcg_pair_table.sv
module lcg_pair_table
    import lcg_pkg::*;
#(
    parameter int CNT_W = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             inc_valid,
    input  mc_id_t           inc_mc,
    input  bank_id_t         inc_bank,
    input  logic             dec_valid,
    input  mc_id_t           dec_mc,
    input  bank_id_t         dec_bank,
    output logic [PAIRS-1:0] idle_vec,
    output logic             dec_taken
);
    logic [PAIRS-1:0] inc_sel;
    logic [PAIRS-1:0] dec_sel;

    always_comb begin
        inc_sel = '0;
        dec_sel = '0;
        if (inc_valid) inc_sel[pair_of(inc_mc, inc_bank)] = 1'b1;
        if (dec_valid) dec_sel[pair_of(dec_mc, dec_bank)] = 1'b1;
    end

    // R9: completions aimed at an empty pair are dropped
    assign dec_taken = dec_valid && !idle_vec[pair_of(dec_mc, dec_bank)];

    for (genvar p = 0; p < PAIRS; p++) begin : g_pair
        logic [CNT_W-1:0] cnt;
        lcg_sat_cnt #(.W(CNT_W)) u_cnt (
            .clk (clk),
            .rst (rst),
            .inc (inc_sel[p]),
            .dec (dec_sel[p]),
            .cnt (cnt)
        );
        assign idle_vec[p] = (cnt == '0);
    end
endmodule

// File: rtl/lcg_issue_seq.sv
module lcg_issue_seq
    import lcg_pkg::*;
#(
    parameter int GRP_MAX = 4,
    parameter int LEN_W   = $clog2(GRP_MAX + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [LEN_W-1:0] load_len,
    input  lcg_req_t         load_reqs [GRP_MAX],
    input  logic             out_ready,
    output logic             busy,
    output logic             out_valid,
    output lcg_req_t         out_req,
    output logic             fire
);
    localparam int IDX_W = (GRP_MAX > 1) ? $clog2(GRP_MAX) : 1;

    lcg_state_e       state;
    logic [IDX_W-1:0] idx;
    logic [LEN_W-1:0] len_q;
    lcg_req_t         slots [GRP_MAX];

    assign busy      = (state == LCG_SEND);
    assign out_valid = busy;
    assign out_req   = slots[idx];
    assign fire      = out_valid && out_ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= LCG_IDLE;
            idx   <= '0;
            len_q <= '0;
        end else begin
            case (state)
                LCG_IDLE: begin
                    if (load) begin
                        state <= LCG_SEND;
                        idx   <= '0;
                        len_q <= load_len;
                    end
                end
                LCG_SEND: begin
                    if (fire) begin
                        if (LEN_W'(idx) == len_q - LEN_W'(1)) begin
                            state <= LCG_IDLE;
                            idx   <= '0;
                        end else begin
                            idx <= idx + 1'b1;
                        end
                    end
                end
                default: state <= LCG_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (state == LCG_IDLE && load) begin
            for (int i = 0; i < GRP_MAX; i++) slots[i] <= load_reqs[i];
        end
    end

    // R5: an accepted group starts sending on the next cycle
    p_load_sends_r5: assert property (@(posedge clk) disable iff (rst)
        (load && !busy) |=> out_valid);
    // R5: a stalled request is held unchanged
    p_hold_r5: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_req)));
endmodule

// File: rtl/lcg_inject_gate.sv
module lcg_inject_gate
    import lcg_pkg::*;
#(
    parameter int GRP_MAX = 4,
    parameter int CNT_W   = 3,
    parameter int OUT_W   = 5,
    parameter int LEN_W   = $clog2(GRP_MAX + 1)
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic [OUT_W-1:0]          cfg_limit,
    input  logic                      grp_valid,
    output logic                      grp_ready,
    input  logic [LEN_W-1:0]          grp_len,
    input  logic [GRP_MAX*MC_W-1:0]   grp_mc,
    input  logic [GRP_MAX*BANK_W-1:0] grp_bank,
    input  logic [GRP_MAX*TAG_W-1:0]  grp_tag,
    output logic                      inj_valid,
    input  logic                      inj_ready,
    output logic [MC_W-1:0]           inj_mc,
    output logic [BANK_W-1:0]         inj_bank,
    output logic [TAG_W-1:0]          inj_tag,
    input  logic                      cpl_valid,
    input  logic [MC_W-1:0]           cpl_mc,
    input  logic [BANK_W-1:0]         cpl_bank,
    output logic [OUT_W-1:0]          out_count
);
    lcg_req_t         reqs [GRP_MAX];
    logic [PAIRS-1:0] idle_vec;
    logic             dec_taken;
    logic             busy;
    logic             fire;
    logic             any_hot;
    logic             under_limit;
    logic             accept;
    lcg_req_t         cur_req;

    for (genvar s = 0; s < GRP_MAX; s++) begin : g_slot
        assign reqs[s].mc   = grp_mc[s*MC_W +: MC_W];
        assign reqs[s].bank = grp_bank[s*BANK_W +: BANK_W];
        assign reqs[s].tag  = grp_tag[s*TAG_W +: TAG_W];
    end

    // R2/R3: any live slot hitting a pair with traffic in flight
    always_comb begin
        any_hot = 1'b0;
        for (int s = 0; s < GRP_MAX; s++) begin
            if (LEN_W'(s) < grp_len && !idle_vec[pair_of(reqs[s].mc, reqs[s].bank)])
                any_hot = 1'b1;
        end
    end

    assign under_limit = (out_count < cfg_limit);
    assign grp_ready   = !busy && !any_hot && under_limit;
    assign accept      = grp_valid && grp_ready;

    lcg_issue_seq #(.GRP_MAX(GRP_MAX), .LEN_W(LEN_W)) u_seq (
        .clk       (clk),
        .rst       (rst),
        .load      (accept),
        .load_len  (grp_len),
        .load_reqs (reqs),
        .out_ready (inj_ready),
        .busy      (busy),
        .out_valid (inj_valid),
        .out_req   (cur_req),
        .fire      (fire)
    );

    assign inj_mc   = cur_req.mc;
    assign inj_bank = cur_req.bank;
    assign inj_tag  = cur_req.tag;

    lcg_pair_table #(.CNT_W(CNT_W)) u_table (
        .clk       (clk),
        .rst       (rst),
        .inc_valid (fire),
        .inc_mc    (cur_req.mc),
        .inc_bank  (cur_req.bank),
        .dec_valid (cpl_valid),
        .dec_mc    (cpl_mc),
        .dec_bank  (cpl_bank),
        .idle_vec  (idle_vec),
        .dec_taken (dec_taken)
    );

    lcg_sat_cnt #(.W(OUT_W)) u_out (
        .clk (clk),
        .rst (rst),
        .inc (fire),
        .dec (dec_taken),
        .cnt (out_count)
    );

    // R1: state after reset
    p_reset_r1: assert property (@(posedge clk)
        $past(rst) |-> (!inj_valid && out_count == '0));
    // R4: never admit at or above the limit
    p_limit_r4: assert property (@(posedge clk) disable iff (rst)
        grp_ready |-> (out_count < cfg_limit));
    // R6: no admission while sending
    p_busy_blocks_r6: assert property (@(posedge clk) disable iff (rst)
        inj_valid |-> !grp_ready);
    // R8: outstanding count moves only on traffic
    p_quiet_r8: assert property (@(posedge clk) disable iff (rst)
        (!fire && !cpl_valid) |=> $stable(out_count));
endmodule

// File: tb/test_lcg_inject_gate.sv
module test_lcg_inject_gate;
    import lcg_pkg::*;

    localparam int GM = 4;
    localparam int OW = 5;
    localparam int LW = $clog2(GM + 1);

    logic              clk = 1'b0;
    logic              rst;
    logic [OW-1:0]     cfg_limit;
    logic              grp_valid;
    logic              grp_ready;
    logic [LW-1:0]     grp_len;
    logic [GM*MC_W-1:0]   grp_mc;
    logic [GM*BANK_W-1:0] grp_bank;
    logic [GM*TAG_W-1:0]  grp_tag;
    logic              inj_valid;
    logic              inj_ready;
    logic [MC_W-1:0]   inj_mc;
    logic [BANK_W-1:0] inj_bank;
    logic [TAG_W-1:0]  inj_tag;
    logic              cpl_valid;
    logic [MC_W-1:0]   cpl_mc;
    logic [BANK_W-1:0] cpl_bank;
    logic [OW-1:0]     out_count;

    always #4 clk = ~clk;

    lcg_inject_gate #(.GRP_MAX(GM), .OUT_W(OW)) i_lcg_inject_gate (
        .clk(clk), .rst(rst), .cfg_limit(cfg_limit),
        .grp_valid(grp_valid), .grp_ready(grp_ready), .grp_len(grp_len),
        .grp_mc(grp_mc), .grp_bank(grp_bank), .grp_tag(grp_tag),
        .inj_valid(inj_valid), .inj_ready(inj_ready), .inj_mc(inj_mc),
        .inj_bank(inj_bank), .inj_tag(inj_tag),
        .cpl_valid(cpl_valid), .cpl_mc(cpl_mc), .cpl_bank(cpl_bank),
        .out_count(out_count)
    );

    int n_chk = 0;
    int n_fail = 0;
    logic [MC_W+BANK_W+TAG_W-1:0] expq[$];
    logic [MC_W-1:0]   s_mc   [GM];
    logic [BANK_W-1:0] s_bank [GM];
    logic [TAG_W-1:0]  s_tag  [GM];

    task automatic chk(bit ok, string req, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // scoreboard monitor: pops one expected item per output handshake
    always @(negedge clk) begin
        if (!rst && inj_valid) begin
            chk(!grp_ready, "R6 grp_ready while sending", int'(grp_ready), 0);
            if (inj_ready) begin
                if (expq.size() == 0) begin
                    chk(1'b0, "R3 unexpected injection", int'(inj_tag), -1);
                end else begin
                    automatic logic [MC_W+BANK_W+TAG_W-1:0] e = expq.pop_front();
                    chk({inj_mc, inj_bank, inj_tag} == e, "R5 R10 order and fields",
                        int'({inj_mc, inj_bank, inj_tag}), int'(e));
                end
            end
        end
    end

    task automatic slot(int i, int mc, int bank, int tag);
        s_mc[i] = MC_W'(mc); s_bank[i] = BANK_W'(bank); s_tag[i] = TAG_W'(tag);
    endtask

    task automatic offer(int len, bit expect_acc, string req);
        @(posedge clk); #1;
        grp_len = LW'(len);
        for (int i = 0; i < GM; i++) begin
            grp_mc[i*MC_W +: MC_W]       = s_mc[i];
            grp_bank[i*BANK_W +: BANK_W] = s_bank[i];
            grp_tag[i*TAG_W +: TAG_W]    = s_tag[i];
        end
        grp_valid = 1'b1;
        if (expect_acc) begin
            automatic bit got = 1'b0;
            for (int k = 0; k < 30; k++) begin
                @(negedge clk);
                if (grp_ready) begin
                    for (int i = 0; i < len; i++) expq.push_back({s_mc[i], s_bank[i], s_tag[i]});
                    got = 1'b1;
                    break;
                end
            end
            chk(got, req, int'(got), 1);
        end else begin
            for (int k = 0; k < 4; k++) begin
                @(negedge clk);
                chk(!grp_ready, req, int'(grp_ready), 0);
            end
        end
        @(posedge clk); #1;
        grp_valid = 1'b0;
    endtask

    task automatic drain();
        for (int k = 0; k < 50; k++) begin
            @(negedge clk);
            if (!inj_valid && expq.size() == 0) break;
        end
    endtask

    task automatic complete(int mc, int bank);
        @(posedge clk); #1;
        cpl_valid = 1'b1; cpl_mc = MC_W'(mc); cpl_bank = BANK_W'(bank);
        @(posedge clk); #1;
        cpl_valid = 1'b0;
    endtask

    task automatic check_out(int exp, string req);
        @(negedge clk);
        chk(int'(out_count) == exp, req, int'(out_count), exp);
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        #(8 * 20000);
        chk(1'b0, "watchdog expired", 0, 1);
        finish_run();
    end

    initial begin
        rst = 1'b1; cfg_limit = OW'(8); grp_valid = 1'b0; grp_len = '0;
        grp_mc = '0; grp_bank = '0; grp_tag = '0; inj_ready = 1'b1;
        cpl_valid = 1'b0; cpl_mc = '0; cpl_bank = '0;
        for (int i = 0; i < GM; i++) slot(i, 0, 0, 0);
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        chk(!inj_valid, "R1 inj_valid after reset", int'(inj_valid), 0);
        chk(out_count == 0, "R1 out_count after reset", int'(out_count), 0);

        // R2: fresh banks pass, three requests
        slot(0, 0, 0, 8'h11); slot(1, 0, 1, 8'h12); slot(2, 1, 2, 8'h13);
        offer(3, 1'b1, "R2 fresh group accepted");
        drain();
        check_out(3, "R7 count after three injections");

        // R3: reuse of busy pair (0,1) is held
        slot(0, 0, 1, 8'h21); slot(1, 1, 3, 8'h22);
        offer(2, 1'b0, "R3 busy pair throttles");
        complete(0, 1);
        check_out(2, "R8 completion lowers count");
        offer(2, 1'b1, "R2 accepted after pair freed");
        drain();
        check_out(4, "R7 count after second group");

        // R9: completion to an idle pair is ignored
        complete(1, 1);
        check_out(4, "R9 stray completion ignored");

        // R4: limit equal to the count holds, raising it admits
        cfg_limit = OW'(4);
        slot(0, 1, 0, 8'h31); slot(1, 1, 0, 8'h32);
        offer(2, 1'b0, "R4 limit reached throttles");
        cfg_limit = OW'(5);
        offer(2, 1'b1, "R4 raised limit admits");
        drain();
        check_out(6, "R7 count after same-bank pair");

        // R5/R6: stalled output, busy gate, same-edge inject and complete
        cfg_limit = OW'(16);
        @(posedge clk); #1 inj_ready = 1'b0;
        slot(0, 1, 1, 8'h41); slot(1, 0, 2, 8'h42); slot(2, 0, 3, 8'h43); slot(3, 1, 1, 8'h44);
        offer(4, 1'b1, "R2 four-slot group accepted");
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            chk(inj_valid && inj_tag == 8'h41, "R5 stalled request held", int'(inj_tag), 'h41);
        end
        slot(0, 0, 2, 8'h51);
        offer(1, 1'b0, "R6 gate busy holds group");
        check_out(6, "R5 no count change while stalled");
        @(posedge clk); #1;
        inj_ready = 1'b1; cpl_valid = 1'b1; cpl_mc = '0; cpl_bank = '0;
        @(posedge clk); #1;
        cpl_valid = 1'b0;
        @(negedge clk);
        chk(out_count == 6, "R8 same-edge inject and complete nets zero", int'(out_count), 6);
        drain();
        check_out(9, "R7 count after stalled group");

        // R3: pair (0,2) now in flight, same group held
        slot(0, 0, 2, 8'h51);
        offer(1, 1'b0, "R3 pair busy after drain");

        // R2: freed pair (0,0) admits again
        slot(0, 0, 0, 8'h61);
        offer(1, 1'b1, "R2 freed pair admits");
        drain();
        check_out(10, "R7 final count");
        chk(expq.size() == 0, "R5 all expected requests seen", expq.size(), 0);

        finish_run();
    end
endmodule